// File: doc/BRIEF.md
# Integer ALU with Condition-Code Register

This block is the integer execution unit of a small CPU core. Each issued operation takes two 32-bit operands, a size select of byte, word or long, and an operation code. It produces a result merged into the destination value and a write-enable strobe. It also keeps an 8-bit condition-code register. The arithmetic group covers add, add with carry, subtract, subtract with borrow, negate, increment, decrement and compare. The logical group covers AND, OR, XOR and move. Three more operations apply an immediate AND, OR or XOR directly to the condition-code register.

Results, the write strobe and the flags are registered. They appear one clock after an operation is issued with `valid` high. A combinational branch-condition output tests the registered flags against a 4-bit condition select. The decode stage uses this output to resolve conditional branches.

Top module: `alu_ccr`

## Requirements
- R1: While `rst_n` is low at a clock edge, `ccr` loads the parameter `CCR_RESET`, and `result` and `wr_en` load zero.
- R2: Operation codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 negate, 5 increment, 6 decrement, 7 compare, 8 AND, 9 OR, 10 XOR, 11 move, 12 flag-AND, 13 flag-OR, 14 flag-XOR and 15 no-operation. An edge with `valid` high applies the operation, so the new `ccr`, `result` and `wr_en` appear after that edge. An edge with `valid` low changes neither `ccr` nor `result` and leaves `wr_en` low, and code 15 changes nothing.
- R3: `size` 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Result bits above the selected width are copied from `a`. N is the result bit at the top of the width, and Z is set when the result is zero within the width.
- R4: Add computes a+b, and add-with-carry computes a+b+C. C is the carry out of the top bit and H is the carry out of bit width-5 (bit 3, 11 or 27). V is set when a and b have equal signs and the result sign differs from a.
- R5: Subtract computes a-b, subtract-with-borrow computes a-b-C, and negate computes 0-a. C is the borrow out of the width and H is the borrow out of bit width-5. V is set when the operand signs differ and the result sign differs from the minuend.
- R6: Increment adds a step to a and decrement subtracts it. The step code `b[1:0]` gives 0 for 1, 1 for 2 and 2 or 3 for 4. Bytes always step by 1, and words cap the step at 2. V flags a signed wrap: positive to negative for increment, negative to positive for decrement. C and H are left unchanged.
- R7: Compare sets N, Z, V, C and H as subtract does. It never raises `wr_en`, and `result` holds its previous value.
- R8: AND, OR, XOR and move (which takes b) write the result, clear V, and leave C and H unchanged.
- R9: Flag-AND, flag-OR and flag-XOR replace all eight `ccr` bits with `ccr` combined with `b[7:0]`. They never raise `wr_en`, and `result` holds its value.
- R10: The `ccr` bit layout is 7 interrupt mask, 6 user bit, 5 H, 4 user bit, 3 N, 2 Z, 1 V, 0 C. Codes 0 to 11 leave bits 7, 6 and 4 unchanged.
- R11: `cond_true` evaluates `cond` against the registered flags. The codes are 0 always, 1 never, 2 C|Z==0, 3 C|Z==1, 4 C==0, 5 C==1, 6 Z==0, 7 Z==1, 8 V==0, 9 V==1, 10 N==0, 11 N==1, 12 N^V==0, 13 N^V==1, 14 Z|(N^V)==0 and 15 Z|(N^V)==1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid | input | 1 | Issue strobe for the operation on op/size/a/b |
| op | input | 4 | Operation code |
| size | input | 2 | Operand width select |
| a | input | 32 | Destination/first operand |
| b | input | 32 | Source operand, step code or flag immediate |
| cond | input | 4 | Branch condition select |
| result | output | 32 | Registered result merged into a |
| wr_en | output | 1 | Registered write strobe for result |
| ccr | output | 8 | Condition-code register |
| cond_true | output | 1 | Selected condition holds on ccr |

## Verification
The bench instantiates the block with `CCR_RESET` set to 8'hC5 rather than the default. The reset check therefore sees a pattern with set interrupt, user and carry bits. The very first add-with-carry and subtract-with-borrow run with C already set. Because the user and mask bits start at one, preserving them across arithmetic is a visible check rather than a zero staying zero.

// File: rtl/alu_ccr.sv
module alu_ccr #(
  parameter logic [7:0] CCR_RESET = 8'h80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid,
  input  logic [3:0]  op,
  input  logic [1:0]  size,
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  logic [3:0]  cond,
  output logic [31:0] result,
  output logic        wr_en,
  output logic [7:0]  ccr,
  output logic        cond_true
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADDC = 4'd1, OP_SUB = 4'd2, OP_SUBC = 4'd3;
  localparam logic [3:0] OP_NEG = 4'd4, OP_INC = 4'd5, OP_DEC = 4'd6, OP_CMP = 4'd7;
  localparam logic [3:0] OP_AND = 4'd8, OP_OR = 4'd9, OP_XOR = 4'd10, OP_MOV = 4'd11;
  localparam logic [3:0] OP_CAND = 4'd12, OP_COR = 4'd13, OP_CXOR = 4'd14;

  logic [4:0]  sh;
  logic [31:0] wmask, step, x, y, xs, ys, lres, r_sel, rs, res_n;
  logic        cin, sub, arith, writes;
  logic [32:0] cin_s, sum33;
  logic [28:0] lo29;
  logic        a_co, a_h, a_v, n_f, z_f;
  logic [7:0]  ccr_n;

  always_comb begin
    case (size)
      2'd0:    sh = 5'd24;
      2'd1:    sh = 5'd16;
      default: sh = 5'd0;
    endcase
  end
  assign wmask = 32'hFFFF_FFFF >> sh;

  always_comb begin
    if (size == 2'd0)                  step = 32'd1;
    else if (b[1:0] == 2'd0)           step = 32'd1;
    else if (b[1:0] == 2'd1 || size == 2'd1) step = 32'd2;
    else                               step = 32'd4;
  end

  always_comb begin
    x = a; y = b; cin = 1'b0; sub = 1'b0; arith = 1'b1;
    case (op)
      OP_ADD:  ;
      OP_ADDC: cin = ccr[0];
      OP_SUB, OP_CMP: begin y = ~b; cin = 1'b1; sub = 1'b1; end
      OP_SUBC: begin y = ~b; cin = ~ccr[0]; sub = 1'b1; end
      OP_NEG:  begin x = 32'd0; y = ~a; cin = 1'b1; sub = 1'b1; end
      OP_INC:  y = step;
      OP_DEC:  begin y = ~step; cin = 1'b1; end
      default: arith = 1'b0;
    endcase
  end

  assign xs    = x << sh;
  assign ys    = y << sh;
  assign cin_s = {32'd0, cin} << sh;
  assign sum33 = {1'b0, xs} + {1'b0, ys} + cin_s;
  assign lo29  = {1'b0, xs[27:0]} + {1'b0, ys[27:0]} + cin_s[28:0];
  assign a_co  = sum33[32];
  assign a_h   = lo29[28];
  assign a_v   = (xs[31] == ys[31]) && (sum33[31] != xs[31]);

  always_comb begin
    case (op)
      OP_AND:  lres = a & b;
      OP_OR:   lres = a | b;
      OP_XOR:  lres = a ^ b;
      default: lres = b;
    endcase
  end

  assign r_sel  = arith ? (sum33[31:0] >> sh) : (lres & wmask);
  assign rs     = r_sel << sh;
  assign n_f    = rs[31];
  assign z_f    = (r_sel & wmask) == 32'd0;
  assign res_n  = (a & ~wmask) | (r_sel & wmask);
  assign writes = (op < OP_CAND) && (op != OP_CMP);

  always_comb begin
    ccr_n = ccr;
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_NEG, OP_CMP: begin
        ccr_n[5] = a_h ^ sub;
        ccr_n[3] = n_f;
        ccr_n[2] = z_f;
        ccr_n[1] = a_v;
        ccr_n[0] = a_co ^ sub;
      end
      OP_INC, OP_DEC: begin
        ccr_n[3] = n_f; ccr_n[2] = z_f; ccr_n[1] = a_v;
      end
      OP_AND, OP_OR, OP_XOR, OP_MOV: begin
        ccr_n[3] = n_f; ccr_n[2] = z_f; ccr_n[1] = 1'b0;
      end
      OP_CAND: ccr_n = ccr & b[7:0];
      OP_COR:  ccr_n = ccr | b[7:0];
      OP_CXOR: ccr_n = ccr ^ b[7:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccr    <= CCR_RESET;
      result <= 32'd0;
      wr_en  <= 1'b0;
    end else begin
      wr_en <= valid && writes;
      if (valid) ccr <= ccr_n;
      if (valid && writes) result <= res_n;
    end
  end

  always_comb begin
    case (cond)
      4'd0:  cond_true = 1'b1;
      4'd1:  cond_true = 1'b0;
      4'd2:  cond_true = !(ccr[0] | ccr[2]);
      4'd3:  cond_true = ccr[0] | ccr[2];
      4'd4:  cond_true = !ccr[0];
      4'd5:  cond_true = ccr[0];
      4'd6:  cond_true = !ccr[2];
      4'd7:  cond_true = ccr[2];
      4'd8:  cond_true = !ccr[1];
      4'd9:  cond_true = ccr[1];
      4'd10: cond_true = !ccr[3];
      4'd11: cond_true = ccr[3];
      4'd12: cond_true = !(ccr[3] ^ ccr[1]);
      4'd13: cond_true = ccr[3] ^ ccr[1];
      4'd14: cond_true = !(ccr[2] | (ccr[3] ^ ccr[1]));
      default: cond_true = ccr[2] | (ccr[3] ^ ccr[1]);
    endcase
  end

  function automatic logic zero_at(input logic [31:0] v, input logic [1:0] s);
    case (s)
      2'd0:    zero_at = v[7:0] == 8'd0;
      2'd1:    zero_at = v[15:0] == 16'd0;
      default: zero_at = v == 32'd0;
    endcase
  endfunction

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> ($stable(ccr) && $stable(result) && !wr_en));
  // R3
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ccr[2] == zero_at(result, $past(size))));
  // R6
  step_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (op == OP_INC || op == OP_DEC)) |=> (ccr[0] == $past(ccr[0]) && ccr[5] == $past(ccr[5])));
  // R7
  compare_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op == OP_CMP) |=> (!wr_en && $stable(result)));
  // R8
  logic_v_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op >= OP_AND && op <= OP_MOV) |=> (!ccr[1] && ccr[0] == $past(ccr[0])));
  // R10
  user_bits_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && op < OP_CAND) |=> (ccr[7:6] == $past(ccr[7:6]) && ccr[4] == $past(ccr[4])));
endmodule

// File: tb/tb_alu_ccr.sv
`timescale 1ns/1ps
module tb_alu_ccr;
  localparam logic [7:0] RST_CCR = 8'hC5;

  logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0;
  logic [3:0] op = 4'd0, cond = 4'd0;
  logic [1:0] size = 2'd0;
  logic [31:0] a = 32'd0, b = 32'd0;
  logic [31:0] result;
  logic wr_en, cond_true;
  logic [7:0] ccr;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0]  m_ccr;
  logic [31:0] m_res;

  alu_ccr #(.CCR_RESET(RST_CCR)) dut (
    .clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .size(size), .a(a), .b(b),
    .cond(cond), .result(result), .wr_en(wr_en), .ccr(ccr), .cond_true(cond_true));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic logic [40:0] model(input logic [3:0] o, input logic [1:0] sz,
      input logic [31:0] av, input logic [31:0] bv, input logic [7:0] c, input logic [31:0] prev);
    int w;
    longint m, msb, hm, hb, A, B, s, r, st, cin;
    logic [7:0] nc;
    bit we;
    logic [31:0] res;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m = (longint'(1) << w) - 1;
    msb = longint'(1) << (w - 1);
    hb = longint'(1) << (w - 4);
    hm = hb - 1;
    A = longint'(av) & m;
    B = longint'(bv) & m;
    nc = c; r = 0; we = 1;
    case (o)
      4'd0, 4'd1: begin
        cin = (o == 4'd1) ? longint'(c[0]) : 0;
        s = A + B + cin;
        nc[0] = ((s >> w) & 1) != 0;
        nc[5] = ((A & hm) + (B & hm) + cin) >= hb;
        r = s & m;
        nc[1] = ((A & msb) == (B & msb)) && ((r & msb) != (A & msb));
      end
      4'd2, 4'd3, 4'd7: begin
        cin = (o == 4'd3) ? longint'(c[0]) : 0;
        s = A - B - cin;
        nc[0] = s < 0;
        nc[5] = ((A & hm) - (B & hm) - cin) < 0;
        r = s & m;
        nc[1] = ((A & msb) != (B & msb)) && ((r & msb) != (A & msb));
        we = (o != 4'd7);
      end
      4'd4: begin
        r = (-A) & m;
        nc[0] = A != 0;
        nc[5] = (A & hm) != 0;
        nc[1] = A == msb;
      end
      4'd5, 4'd6: begin
        st = (bv[1:0] == 2'd0) ? 1 : (bv[1:0] == 2'd1) ? 2 : 4;
        if (w == 8) st = 1;
        if (w == 16 && st == 4) st = 2;
        if (o == 4'd5) begin
          r = (A + st) & m;
          nc[1] = ((A & msb) == 0) && ((r & msb) != 0);
        end else begin
          r = (A - st) & m;
          nc[1] = ((A & msb) != 0) && ((r & msb) == 0);
        end
      end
      4'd8:  begin r = A & B; nc[1] = 0; end
      4'd9:  begin r = A | B; nc[1] = 0; end
      4'd10: begin r = A ^ B; nc[1] = 0; end
      4'd11: begin r = B;     nc[1] = 0; end
      4'd12: begin nc = c & bv[7:0]; we = 0; end
      4'd13: begin nc = c | bv[7:0]; we = 0; end
      4'd14: begin nc = c ^ bv[7:0]; we = 0; end
      default: we = 0;
    endcase
    if (o < 4'd12) begin
      nc[3] = (r & msb) != 0;
      nc[2] = r == 0;
    end
    res = we ? ((av & ~32'(m)) | 32'(r)) : prev;
    return {we, nc, res};
  endfunction

  function automatic bit cond_model(input logic [3:0] cs, input logic [7:0] c);
    bit n, z, v, cy;
    n = c[3]; z = c[2]; v = c[1]; cy = c[0];
    case (cs)
      4'd0: return 1; 4'd1: return 0;
      4'd2: return !(cy | z); 4'd3: return cy | z;
      4'd4: return !cy; 4'd5: return cy;
      4'd6: return !z; 4'd7: return z;
      4'd8: return !v; 4'd9: return v;
      4'd10: return !n; 4'd11: return n;
      4'd12: return !(n ^ v); 4'd13: return n ^ v;
      4'd14: return !(z | (n ^ v));
      default: return z | (n ^ v);
    endcase
  endfunction

  function automatic string op_tag(input logic [3:0] o);
    if (o <= 4'd1) return "R4";
    if (o <= 4'd4) return "R5";
    if (o <= 4'd6) return "R6";
    if (o == 4'd7) return "R7";
    if (o <= 4'd11) return "R8";
    if (o <= 4'd14) return "R9";
    return "R2";
  endfunction

  task automatic do_op(input logic [3:0] o, input logic [1:0] sz, input logic [31:0] av, input logic [31:0] bv);
    logic [40:0] e;
    logic [31:0] hmask;
    e = model(o, sz, av, bv, m_ccr, m_res);
    @(negedge clk);
    valid = 1'b1; op = o; size = sz; a = av; b = bv;
    @(negedge clk);
    valid = 1'b0;
    chk(result == e[31:0], op_tag(o), 64'(result), 64'(e[31:0]));
    chk(ccr == e[39:32], op_tag(o), 64'(ccr), 64'(e[39:32]));
    chk(wr_en == e[40], op_tag(o), 64'(wr_en), 64'(e[40]));
    if (o < 4'd12)
      chk({ccr[7:6], ccr[4]} == {m_ccr[7:6], m_ccr[4]}, "R10", 64'(ccr), 64'(m_ccr));
    if (e[40] && sz < 2'd2) begin
      hmask = (sz == 2'd0) ? 32'hFFFF_FF00 : 32'hFFFF_0000;
      chk((result & hmask) == (av & hmask), "R3", 64'(result), 64'(av));
    end
    m_ccr = e[39:32];
    m_res = e[31:0];
    cond = 4'($urandom);
    #0.5;
    chk(cond_true == cond_model(cond, m_ccr), "R11", 64'(cond_true), 64'(cond_model(cond, m_ccr)));
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 8)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h0000_007F;
      3: return 32'h0000_8000;
      4: return 32'h7FFF_FFFF;
      5: return 32'h8000_0000;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #600000;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ccr == RST_CCR, "R1", 64'(ccr), 64'(RST_CCR));
    chk(result == 32'd0, "R1", 64'(result), 64'd0);
    chk(wr_en == 1'b0, "R1", 64'(wr_en), 64'd0);
    rst_n = 1'b1;
    m_ccr = RST_CCR;
    m_res = 32'd0;

    // directed corners
    do_op(4'd1, 2'd0, 32'hAAAA_BB01, 32'h0000_0001); // R4 addc with C=1 from reset
    do_op(4'd0, 2'd0, 32'h1234_567F, 32'h0000_0001); // R4 byte V,H,N
    do_op(4'd0, 2'd0, 32'h0000_00FF, 32'h0000_0001); // R4 byte C,Z
    do_op(4'd0, 2'd1, 32'h0000_0FFF, 32'h0000_0001); // R4 word H from bit 11
    do_op(4'd2, 2'd1, 32'hDEAD_8000, 32'h0000_0001); // R5 word V
    do_op(4'd4, 2'd2, 32'h8000_0000, 32'd0);         // R5 negate of min
    do_op(4'd4, 2'd3, 32'h0000_0000, 32'd0);         // R5 negate of zero, size 3
    do_op(4'd5, 2'd0, 32'h0000_007F, 32'h0000_0003); // R6 byte step forced to 1
    do_op(4'd6, 2'd1, 32'h0000_8001, 32'h0000_0003); // R6 word step capped at 2
    do_op(4'd5, 2'd2, 32'h7FFF_FFFC, 32'h0000_0002); // R6 long step 4
    do_op(4'd7, 2'd2, 32'h0000_0005, 32'h0000_0005); // R7 compare equal
    do_op(4'd8, 2'd0, 32'hFFFF_FF0F, 32'h0000_00F0); // R8 AND zero
    do_op(4'd11, 2'd1, 32'h1111_2222, 32'h0000_8000); // R8 move
    do_op(4'd13, 2'd0, 32'd0, 32'h0000_00FF);        // R9 flag-OR
    do_op(4'd12, 2'd0, 32'd0, 32'h0000_000A);        // R9 flag-AND
    do_op(4'd14, 2'd0, 32'd0, 32'h0000_0004);        // R9 flag-XOR
    do_op(4'd15, 2'd2, 32'h5555_5555, 32'h1);        // R2 no-op

    // R11 all conditions on a fixed flag pattern
    do_op(4'd12, 2'd0, 32'd0, 32'h0000_0000);
    do_op(4'd13, 2'd0, 32'd0, 32'h0000_0008);
    for (int k = 0; k < 16; k++) begin
      cond = 4'(k);
      #0.5;
      chk(cond_true == cond_model(cond, m_ccr), "R11", 64'(cond_true), 64'(cond_model(cond, m_ccr)));
    end

    // R2 idle cycle with garbage inputs
    @(negedge clk);
    op = 4'd0; size = 2'd2; a = 32'hFFFF_FFFF; b = 32'h1;
    @(negedge clk);
    chk(ccr == m_ccr, "R2", 64'(ccr), 64'(m_ccr));
    chk(result == m_res, "R2", 64'(result), 64'(m_res));
    chk(wr_en == 1'b0, "R2", 64'(wr_en), 64'd0);

    for (int i = 0; i < 3000; i++)
      do_op(4'($urandom), 2'($urandom), pick(), pick());

    finish_run();
  end
endmodule